// File: doc/BRIEF.md
# Variable Depth Pixel Serializer

This block sits between video memory and the palette lookup. It takes one byte at a time from memory or from a character generator and turns it into a stream of 8-bit palette indices, one per dot clock. Each line uses one of four colour depths: 1, 2, 4 or 8 bits per pixel. Pixels leave each byte most significant bits first. At the three narrow depths the index carries a 4-bit palette bank, latched once per line, above the pixel bits. At 8 bits per pixel the byte is the whole index.

The block asks for bytes with a one-cycle `fetch` pulse. The pulse comes every 8 dots at 1 bit per pixel and every 4 dots at the other depths. At 4 and 8 bits per pixel each pixel is stretched over 2 or 4 dots. Because of this, every line covers the same `ACTIVE_DOTS` dots. The first dot of every line appears a fixed number of cycles after the line start, whatever the depth. The last pixel of the line is never cut off or wrapped round.

A line begins with a one-cycle `line_go` pulse, in which the depth and the bank are captured. The memory returns each byte exactly `FETCH_LAT` cycles after its request. The `blank` input forces the index to zero at once.

Top module: `pixel_serializer`

## Requirements
- R1: Depth code 0 gives 1 bit per pixel, code 1 gives 2, code 2 gives 4 and code 3 gives 8. Pixels are taken from a byte most significant bits first. A pixel lasts 1 dot at codes 0 and 1, 2 dots at code 2 and 4 dots at code 3. At codes 0 and 1, the pixel-field bits of the index above the pixel width are zero.
- R2: At depth codes 0 to 2, a visible index has the latched bank in bits 7:4 and the pixel value, zero-extended, in bits 3:0.
- R3: At depth code 3, a visible index equals the pixel byte and the bank has no effect.
- R4: `fetch` is a one-cycle pulse. The first pulse is in the cycle after `line_go`, and further pulses follow every 8 cycles at depth code 0 and every 4 cycles otherwise. A line has exactly `ACTIVE_DOTS`/8 or `ACTIVE_DOTS`/4 pulses.
- R5: `byte_in` is taken exactly `FETCH_LAT` cycles after the matching `fetch` cycle and is ignored in every other cycle.
- R6: Let the `line_go` cycle be cycle 0. Dot d of the line appears on `pix_idx` in cycle `FETCH_LAT`+3+d, for every depth and for d from 0 to `ACTIVE_DOTS`-1.
- R7: Outside that window of `ACTIVE_DOTS` cycles, and before the first line after reset, `pix_idx` is zero.
- R8: While `blank` is high, `pix_idx` is zero in the same cycle. Blanking does not shift the timing of the pixels that follow it.
- R9: Depth and bank are captured only in the `line_go` cycle. Changes to them during a line have no effect on that line.
- R10: During reset, `fetch` and `pix_idx` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_go | input | 1 | One-cycle pulse at column zero of a line |
| depth | input | 2 | Depth code, captured at `line_go` |
| bank | input | 4 | Palette bank, captured at `line_go` |
| blank | input | 1 | Forces the index to zero |
| byte_in | input | 8 | Pixel byte, valid `FETCH_LAT` cycles after `fetch` |
| fetch | output | 1 | Byte request pulse |
| pix_idx | output | 8 | Palette index for the current dot |

## Verification
A slip in the line cycle counter shows up on `fetch` in the very next cycle, as a request off its 4- or 8-dot grid. About `FETCH_LAT`+2 cycles later it also shows on `pix_idx`, as a dot taken from the wrong byte. A wrong shift step or wrong stretch count gives a wrong index inside the first byte of the line. A wrong captured depth or bank corrupts every visible dot of the line, from dot 0 on. The bench compares every cycle against a model of whole lines, and it changes depth and bank during lines, so stale captured state cannot stay hidden.

// File: rtl/pixel_serializer.sv
module pixel_serializer #(
  parameter int ACTIVE_DOTS = 512,
  parameter int FETCH_LAT   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_go,
  input  logic [1:0] depth,
  input  logic [3:0] bank,
  input  logic       blank,
  input  logic [7:0] byte_in,
  output logic       fetch,
  output logic [7:0] pix_idx
);
  localparam int LAST = ACTIVE_DOTS + FETCH_LAT + 2;
  localparam int CW   = $clog2(LAST + 1) + 1;
  localparam logic [CW-1:0] LAST_W = CW'(LAST);
  localparam logic [CW-1:0] ACT_W  = CW'(ACTIVE_DOTS);
  localparam logic [CW-1:0] LD0    = CW'(FETCH_LAT + 1);
  localparam logic [CW-1:0] ST0    = CW'(FETCH_LAT + 2);
  localparam logic [CW-1:0] ONE_W  = CW'(1);

  logic [CW-1:0] cyc;
  logic [1:0]    depth_q;
  logic [3:0]    bank_q;
  logic [7:0]    shreg;
  logic [7:0]    idx_q;

  logic [CW-1:0] f_pos, l_pos, s_pos;
  logic [2:0]    byte_msk;
  logic [1:0]    pix_msk;
  logic          load, in_stage, pix_end;
  logic [7:0]    shifted, pix_bits, formed;

  assign f_pos    = cyc - ONE_W;
  assign l_pos    = cyc - LD0;
  assign s_pos    = cyc - ST0;
  assign byte_msk = (depth_q == 2'd0) ? 3'd7 : 3'd3;
  assign pix_msk  = (depth_q == 2'd3) ? 2'd3 : (depth_q == 2'd2) ? 2'd1 : 2'd0;

  assign fetch    = (cyc != '0) && (f_pos < ACT_W) && ((f_pos[2:0] & byte_msk) == 3'd0);
  assign load     = (cyc >= LD0) && (l_pos < ACT_W) && ((l_pos[2:0] & byte_msk) == 3'd0);
  assign in_stage = (cyc >= ST0) && (s_pos < ACT_W);
  assign pix_end  = (s_pos[1:0] & pix_msk) == pix_msk;

  always_comb begin
    case (depth_q)
      2'd0:    begin shifted = {shreg[6:0], 1'b0}; pix_bits = {7'd0, shreg[7]};   end
      2'd1:    begin shifted = {shreg[5:0], 2'b0}; pix_bits = {6'd0, shreg[7:6]}; end
      2'd2:    begin shifted = {shreg[3:0], 4'b0}; pix_bits = {4'd0, shreg[7:4]}; end
      default: begin shifted = 8'd0;               pix_bits = shreg;              end
    endcase
  end

  assign formed  = (depth_q == 2'd3) ? pix_bits : {bank_q, pix_bits[3:0]};
  assign pix_idx = blank ? 8'd0 : idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc     <= '0;
      depth_q <= 2'd0;
      bank_q  <= 4'd0;
      shreg   <= 8'd0;
      idx_q   <= 8'd0;
    end else begin
      if (line_go) begin
        cyc     <= ONE_W;
        depth_q <= depth;
        bank_q  <= bank;
      end else if (cyc == LAST_W) begin
        cyc <= '0;
      end else if (cyc != '0) begin
        cyc <= cyc + ONE_W;
      end
      if (load)
        shreg <= byte_in;
      else if (in_stage && pix_end)
        shreg <= shifted;
      idx_q <= in_stage ? formed : 8'd0;
    end
  end

  logic [3:0]    gap_a;
  logic          seen_a;
  logic [CW-1:0] nf_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_a  <= 4'd0;
      seen_a <= 1'b0;
      nf_a   <= '0;
    end else if (line_go) begin
      gap_a  <= 4'd0;
      seen_a <= 1'b0;
      nf_a   <= '0;
    end else if (fetch) begin
      gap_a  <= 4'd0;
      seen_a <= 1'b1;
      nf_a   <= nf_a + ONE_W;
    end else if (gap_a != 4'd15) begin
      gap_a <= gap_a + 4'd1;
    end
  end

  assert_fetch_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && seen_a) |-> (gap_a == ((depth_q == 2'd0) ? 4'd7 : 4'd3)));

  assert_fetch_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == LAST_W) |-> (nf_a == ((depth_q == 2'd0) ? CW'(ACTIVE_DOTS / 8) : CW'(ACTIVE_DOTS / 4))));

  assert_bank_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(line_go) && depth_q != 2'd3 && pix_idx != 8'd0) |-> (pix_idx[7:4] == bank_q));

  assert_one_bit_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(line_go) && depth_q == 2'd0) |-> (pix_idx[3:1] == 3'd0));

  assert_two_bit_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(line_go) && depth_q == 2'd1) |-> (pix_idx[3:2] == 2'd0));

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !line_go |=> ($stable(depth_q) && $stable(bank_q)));
endmodule

// File: tb/pixel_serializer_bench.sv
module pixel_serializer_bench;
  localparam int ACT  = 512;
  localparam int LAT  = 2;
  localparam int TEND = ACT + LAT + 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_go = 1'b0;
  logic [1:0] depth = 2'd0;
  logic [3:0] bank = 4'd0;
  logic       blank = 1'b0;
  logic [7:0] byte_in = 8'd0;
  logic       fetch;
  logic [7:0] pix_idx;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pixel_serializer #(.ACTIVE_DOTS(ACT), .FETCH_LAT(LAT)) u_pixel_serializer (
    .clk(clk), .rst_n(rst_n), .line_go(line_go), .depth(depth), .bank(bank),
    .blank(blank), .byte_in(byte_in), .fetch(fetch), .pix_idx(pix_idx));

  function automatic logic [7:0] mem_byte(int line, int k);
    if (line == 0) return (k % 2 == 0) ? 8'h80 : 8'h01;
    return 8'((line * 37 + k * 13 + (k / 4) * 101) ^ (line << 5) ^ (k << 3));
  endfunction

  task automatic check(string rq, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic run_line(int line, logic [1:0] dep, logic [3:0] bk, int bmode, bit churn);
    int s, dpp, bpp;
    s   = (dep == 2'd0) ? 8 : 4;
    dpp = (dep == 2'd3) ? 4 : (dep == 2'd2) ? 2 : 1;
    bpp = 1 << dep;
    for (int t = 0; t <= TEND; t++) begin
      int d, l, k, j, v;
      logic [7:0] b, ep;
      logic ef;
      string rq;
      @(negedge clk);
      line_go = (t == 0);
      if (t == 0) begin
        depth = dep;
        bank  = bk;
      end else if (churn) begin
        depth = 2'($urandom);
        bank  = 4'($urandom);
      end
      d = t - LAT - 3;
      case (bmode)
        1:       blank = ((t / 37) % 3) == 0;
        2:       blank = (d >= 100) && (d < 140);
        default: blank = 1'b0;
      endcase
      l = t - 1 - LAT;
      if (l >= 0 && l < ACT && (l % s) == 0) byte_in = mem_byte(line, l / s);
      else byte_in = ~mem_byte(line, (l < 0 ? 0 : l) / s) ^ 8'($urandom);
      #1;
      ef = (t >= 1) && (t - 1 < ACT) && ((t - 1) % s == 0);
      check("R4 fetch", {7'd0, fetch}, {7'd0, ef});
      if (blank) begin
        ep = 8'd0; rq = "R8 blank";
      end else if (d < 0 || d >= ACT) begin
        ep = 8'd0; rq = "R7 outside";
      end else begin
        k = d / s;
        j = (d % s) / dpp;
        b = mem_byte(line, k);
        v = (int'(b) >> (8 - (j + 1) * bpp)) & ((1 << bpp) - 1);
        ep = (dep == 2'd3) ? 8'(v) : {bk, 4'(v)};
        if (d == 0) rq = "R6 first dot";
        else if (d == ACT - 1) rq = "R6 last dot";
        else if (d % s == 0) rq = "R5 byte edge";
        else if (dep == 2'd3) rq = "R3 full byte";
        else rq = "R1 R2 pixel";
      end
      if (churn) rq = {rq, " R9"};
      check(rq, pix_idx, ep);
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      #1;
      check("R10 reset fetch", {7'd0, fetch}, 8'd0);
      check("R10 reset idx", pix_idx, 8'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      #1;
      check("R7 idle fetch", {7'd0, fetch}, 8'd0);
      check("R7 idle idx", pix_idx, 8'd0);
    end
    run_line(0, 2'd0, 4'hA, 0, 1'b0);
    run_line(1, 2'd1, 4'h5, 1, 1'b0);
    run_line(2, 2'd2, 4'hC, 2, 1'b0);
    run_line(3, 2'd3, 4'hF, 0, 1'b0);
    run_line(4, 2'd3, 4'h3, 2, 1'b1);
    run_line(5, 2'd2, 4'h0, 1, 1'b1);
    run_line(6, 2'd1, 4'h9, 0, 1'b1);
    run_line(7, 2'd0, 4'h6, 2, 1'b1);
    run_line(8, 2'd0, 4'h1, 1, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule